// File: doc/BRIEF.md
# Sobel Gradient Threshold Unit

This block is an edge classifier for one 3×3 neighbourhood of 8-bit monochrome pixels. The nine pixels arrive side by side on one clock edge, and the block forms the horizontal and the vertical Sobel gradient sums from them. It sets one edge flag for each direction. A flag is set when the size of its sum reaches a shared 8-bit threshold. Both sums and both flags come from one register stage, so each window gives a result one clock later.

An upstream line buffer builds the window. That buffer is not part of this block. It presents a new window on any cycle. An enable input marks the cycles whose results count. When the enable is low, the block registers zeros and ignores the pixels. The square-root magnitude and the handling of image borders are left to other logic.

Top module: `sobel_edge_unit`

## Requirements
- R1: `grad_x_o` is the signed 11-bit two's-complement value (tl + 2·ml + bl) − (tr + 2·mr + br). Here tl..br are the window pixels named by row (t top, m middle, b bottom) and column (l left, c centre, r right).
- R2: `grad_y_o` is the signed 11-bit two's-complement value (tl + 2·tc + tr) − (bl + 2·bc + br).
- R3: The centre pixel `pix_mc` has no effect on any output.
- R4: `edge_x_o` is 1 exactly when |grad_x| ≥ `thresh`, where `thresh` is an unsigned 8-bit value. The sign of the gradient does not matter.
- R5: `edge_y_o` is decided on its own from |grad_y| ≥ `thresh`, with no regard to the X result.
- R6: When `en` is 0 at a rising edge, all four outputs become 0 after that edge, whatever the pixel and threshold values are.
- R7: The outputs show the inputs sampled at the previous rising edge. The latency is exactly one cycle.
- R8: When `rst` is high at a rising edge, all four outputs become 0 after it. The reset is synchronous and active high.
- R9: The sums reach the extremes +1020 and −1020 without wrapping.
- R10: A threshold of 0 sets both flags on every enabled cycle, even for a flat window. With a threshold of 255, a gradient size of 255 sets its flag and a size of 254 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low forces zero results |
| pix_tl | input | 8 | Top-left pixel |
| pix_tc | input | 8 | Top-centre pixel |
| pix_tr | input | 8 | Top-right pixel |
| pix_ml | input | 8 | Middle-left pixel |
| pix_mc | input | 8 | Centre pixel (unused) |
| pix_mr | input | 8 | Middle-right pixel |
| pix_bl | input | 8 | Bottom-left pixel |
| pix_bc | input | 8 | Bottom-centre pixel |
| pix_br | input | 8 | Bottom-right pixel |
| thresh | input | 8 | Unsigned edge threshold |
| grad_x_o | output | 11 | Signed horizontal gradient sum |
| grad_y_o | output | 11 | Signed vertical gradient sum |
| edge_x_o | output | 1 | Horizontal-gradient edge flag |
| edge_y_o | output | 1 | Vertical-gradient edge flag |

## Verification
Each weight is tested on its own by lighting only the left or right column, or only the top or bottom row, with full-scale values. These windows reach ±1020 and show whether the two kernels, or their signs, have been swapped. Windows that differ only in the centre pixel must give identical results. A single lit corner pixel gives a gradient of exactly 255 or 254, which pins down the greater-or-equal comparison and the flag for a negative sum. Random windows, random thresholds and a random enable then mix all of these and check both directions at once.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    localparam int PIX_W  = 8;
    localparam int GRAD_W = PIX_W + 3;   // 4*max pixel plus sign
    localparam int MAG_W  = PIX_W + 2;   // 4*max pixel, unsigned

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [GRAD_W-1:0] grad_t;
    typedef logic [MAG_W-1:0]         mag_t;

    typedef enum logic {DIR_X = 1'b0, DIR_Y = 1'b1} dir_e;

    // Three pixels along one side of the window; 'mid' carries weight two.
    typedef struct packed {
        pix_t a;
        pix_t mid;
        pix_t b;
    } side_t;

    typedef struct packed {
        grad_t grad;
        logic  hit;
    } dir_res_t;

    // Weighted side sum; doubling is a plain one-bit shift in the wiring.
    function automatic grad_t side_sum(side_t s);
        grad_t ea, em, eb;
        ea = grad_t'({3'b000, s.a});
        em = grad_t'({2'b00, s.mid, 1'b0});
        eb = grad_t'({3'b000, s.b});
        return ea + em + eb;
    endfunction

    function automatic mag_t magnitude(grad_t g);
        grad_t n;
        n = g[GRAD_W-1] ? -g : g;
        return n[MAG_W-1:0];
    endfunction

endpackage

// File: rtl/sobel_grad.sv
module sobel_grad
    import sobel_pkg::*;
(
    input  side_t lead,
    input  side_t trail,
    output grad_t grad
);
    grad_t lead_sum;
    grad_t trail_sum;

    assign lead_sum  = side_sum(lead);
    assign trail_sum = side_sum(trail);
    assign grad      = lead_sum - trail_sum;
endmodule

// File: rtl/sobel_thresh.sv
module sobel_thresh
    import sobel_pkg::*;
(
    input  grad_t grad,
    input  pix_t  thr,
    output logic  hit
);
    mag_t mag;
    mag_t thr_ext;

    assign mag     = magnitude(grad);
    assign thr_ext = mag_t'(thr);
    assign hit     = (mag >= thr_ext);
endmodule

// File: rtl/sobel_edge_unit.sv
module sobel_edge_unit
    import sobel_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [PIX_W-1:0]         pix_tl,
    input  logic [PIX_W-1:0]         pix_tc,
    input  logic [PIX_W-1:0]         pix_tr,
    input  logic [PIX_W-1:0]         pix_ml,
    input  logic [PIX_W-1:0]         pix_mc,
    input  logic [PIX_W-1:0]         pix_mr,
    input  logic [PIX_W-1:0]         pix_bl,
    input  logic [PIX_W-1:0]         pix_bc,
    input  logic [PIX_W-1:0]         pix_br,
    input  logic [PIX_W-1:0]         thresh,
    output logic signed [GRAD_W-1:0] grad_x_o,
    output logic signed [GRAD_W-1:0] grad_y_o,
    output logic                     edge_x_o,
    output logic                     edge_y_o
);
    localparam int NUM_DIR = 2;

    // The centre pixel carries zero weight in both kernels.
    logic unused_centre;
    assign unused_centre = ^pix_mc;

    side_t lead_s  [NUM_DIR];
    side_t trail_s [NUM_DIR];

    assign lead_s[DIR_X]  = '{a: pix_tl, mid: pix_ml, b: pix_bl};
    assign trail_s[DIR_X] = '{a: pix_tr, mid: pix_mr, b: pix_br};
    assign lead_s[DIR_Y]  = '{a: pix_tl, mid: pix_tc, b: pix_tr};
    assign trail_s[DIR_Y] = '{a: pix_bl, mid: pix_bc, b: pix_br};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        grad_t    grad_c;
        logic     hit_c;
        dir_res_t res_q;

        sobel_grad u_grad (
            .lead  (lead_s[d]),
            .trail (trail_s[d]),
            .grad  (grad_c)
        );

        sobel_thresh u_thr (
            .grad (grad_c),
            .thr  (thresh),
            .hit  (hit_c)
        );

        always_ff @(posedge clk) begin
            if (rst || !en) begin
                res_q <= '0;
            end else begin
                res_q <= '{grad: grad_c, hit: hit_c};
            end
        end
    end

    assign grad_x_o = g_dir[0].res_q.grad;
    assign edge_x_o = g_dir[0].res_q.hit;
    assign grad_y_o = g_dir[1].res_q.grad;
    assign edge_y_o = g_dir[1].res_q.hit;
endmodule

// File: rtl/sobel_edge_chk.sv
module sobel_edge_chk
    import sobel_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     en,
    input logic [PIX_W-1:0]         thresh,
    input logic signed [GRAD_W-1:0] grad_x_o,
    input logic signed [GRAD_W-1:0] grad_y_o,
    input logic                     edge_x_o,
    input logic                     edge_y_o
);
    localparam int LIMIT = 4 * ((1 << PIX_W) - 1);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (grad_x_o == '0 && grad_y_o == '0 && !edge_x_o && !edge_y_o)); // R8

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en |=> (grad_x_o == '0 && grad_y_o == '0 && !edge_x_o && !edge_y_o)); // R6

    AST_EDGE_X_DECIDE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en)) |->
            (edge_x_o == (magnitude(grad_x_o) >= mag_t'($past(thresh))))); // R4

    AST_EDGE_Y_DECIDE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en)) |->
            (edge_y_o == (magnitude(grad_y_o) >= mag_t'($past(thresh))))); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int'(grad_x_o) <= LIMIT && int'(grad_x_o) >= -LIMIT &&
         int'(grad_y_o) <= LIMIT && int'(grad_y_o) >= -LIMIT)); // R9
endmodule

bind sobel_edge_unit sobel_edge_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .thresh   (thresh),
    .grad_x_o (grad_x_o),
    .grad_y_o (grad_y_o),
    .edge_x_o (edge_x_o),
    .edge_y_o (edge_y_o)
);

// File: tb/sobel_edge_unit_tb.sv
`timescale 1ns/1ps
module sobel_edge_unit_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [7:0] w [9];          // row-major: 0..2 top, 3..5 middle, 6..8 bottom
    logic [7:0] thr = 8'd0;
    logic signed [10:0] gx, gy;
    logic ex, ey;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sobel_edge_unit u_dut (
        .clk(clk), .rst(rst), .en(en),
        .pix_tl(w[0]), .pix_tc(w[1]), .pix_tr(w[2]),
        .pix_ml(w[3]), .pix_mc(w[4]), .pix_mr(w[5]),
        .pix_bl(w[6]), .pix_bc(w[7]), .pix_br(w[8]),
        .thresh(thr),
        .grad_x_o(gx), .grad_y_o(gy), .edge_x_o(ex), .edge_y_o(ey)
    );

    function automatic int ref_gx();
        return (int'(w[0]) + 2*int'(w[3]) + int'(w[6])) - (int'(w[2]) + 2*int'(w[5]) + int'(w[8]));
    endfunction

    function automatic int ref_gy();
        return (int'(w[0]) + 2*int'(w[1]) + int'(w[2])) - (int'(w[6]) + 2*int'(w[7]) + int'(w[8]));
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_win(int v0, int v1, int v2, int v3, int v4, int v5, int v6, int v7, int v8);
        w[0] = 8'(v0); w[1] = 8'(v1); w[2] = 8'(v2);
        w[3] = 8'(v3); w[4] = 8'(v4); w[5] = 8'(v5);
        w[6] = 8'(v6); w[7] = 8'(v7); w[8] = 8'(v8);
    endtask

    // Inputs already set; wait for the capturing edge and sample 1 ns later.
    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    // Full comparison of all outputs against the reference model.
    task automatic check_all(string tag);
        int egx, egy, eex, eey;
        egx = en ? ref_gx() : 0;
        egy = en ? ref_gy() : 0;
        eex = (en && iabs(ref_gx()) >= int'(thr)) ? 1 : 0;
        eey = (en && iabs(ref_gy()) >= int'(thr)) ? 1 : 0;
        check({tag, " R1 grad_x"}, int'(gx), egx);
        check({tag, " R2 grad_y"}, int'(gy), egy);
        check({tag, " R4 edge_x"}, int'(ex), eex);
        check({tag, " R5 edge_y"}, int'(ey), eey);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int sgx, sgy;
        void'($urandom(32'd20240607));
        set_win(0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R8: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset grad_x", int'(gx), 0);
        check("R8 reset edge_x", int'(ex), 0);
        check("R8 reset grad_y", int'(gy), 0);
        check("R8 reset edge_y", int'(ey), 0);

        @(negedge clk);
        rst = 1'b0; en = 1'b1;

        // R10: threshold 0 on a flat window sets both flags
        thr = 8'd0; set_win(77, 77, 77, 77, 77, 77, 77, 77, 77);
        settle();
        check("R10 thr0 flat edge_x", int'(ex), 1);
        check("R10 thr0 flat edge_y", int'(ey), 1);

        // R9/R1: left column full, right empty -> +1020
        @(negedge clk); thr = 8'd200;
        set_win(255, 0, 0, 255, 0, 0, 255, 0, 0);
        settle();
        check("R9 R1 max grad_x", int'(gx), 1020);
        check_all("left col");
        // R9/R1: right column full -> -1020, still flagged (R4 sign-free)
        @(negedge clk); set_win(0, 0, 255, 0, 0, 255, 0, 0, 255);
        settle();
        check("R9 R1 min grad_x", int'(gx), -1020);
        check("R4 negative edge_x", int'(ex), 1);
        check_all("right col");
        // R2: top row full -> +1020, bottom full -> -1020
        @(negedge clk); set_win(255, 255, 255, 0, 0, 0, 0, 0, 0);
        settle();
        check("R9 R2 max grad_y", int'(gy), 1020);
        @(negedge clk); set_win(0, 0, 0, 0, 0, 0, 255, 255, 255);
        settle();
        check("R9 R2 min grad_y", int'(gy), -1020);
        check_all("bottom row");

        // R10: threshold 255 boundary with a lone corner pixel
        @(negedge clk); thr = 8'd255; set_win(255, 0, 0, 0, 0, 0, 0, 0, 0);
        settle();
        check("R10 mag255 edge_x", int'(ex), 1);
        check("R10 mag255 edge_y", int'(ey), 1);
        @(negedge clk); set_win(254, 0, 0, 0, 0, 0, 0, 0, 0);
        settle();
        check("R10 mag254 edge_x", int'(ex), 0);
        check("R10 mag254 edge_y", int'(ey), 0);
        // R5: X and Y decided independently
        @(negedge clk); thr = 8'd100; set_win(0, 0, 0, 200, 0, 0, 0, 0, 0);
        settle();
        check("R5 independent edge_x", int'(ex), 1);
        check("R5 independent edge_y", int'(ey), 0);

        // R3: centre pixel has no effect
        @(negedge clk); thr = 8'd90; set_win(12, 200, 45, 99, 0, 7, 180, 33, 61);
        settle();
        sgx = int'(gx); sgy = int'(gy);
        @(negedge clk); w[4] = 8'd255;
        settle();
        check("R3 centre grad_x", int'(gx), sgx);
        check("R3 centre grad_y", int'(gy), sgy);
        check_all("R3 centre");

        // R6: enable low zeros everything even with threshold 0
        @(negedge clk); en = 1'b0; thr = 8'd0; set_win(255, 255, 255, 255, 0, 0, 0, 0, 0);
        settle();
        check("R6 disabled grad_x", int'(gx), 0);
        check("R6 disabled grad_y", int'(gy), 0);
        check("R6 disabled edge_x", int'(ex), 0);
        check("R6 disabled edge_y", int'(ey), 0);

        // R7: one-cycle latency; change after the edge must not show yet
        @(negedge clk); en = 1'b1; thr = 8'd10; set_win(100, 0, 0, 0, 0, 0, 0, 0, 0);
        settle();
        set_win(0, 0, 0, 0, 0, 0, 0, 0, 50);
        #1;
        check("R7 held grad_x", int'(gx), 100);
        settle();
        check("R7 next grad_x", int'(gx), -50);

        // R8: reset in mid-run with live inputs
        @(negedge clk); rst = 1'b1; set_win(255, 0, 0, 255, 0, 0, 255, 0, 0);
        settle();
        check("R8 midrun grad_x", int'(gx), 0);
        check("R8 midrun edge_x", int'(ex), 0);
        @(negedge clk); rst = 1'b0;

        // Random windows, thresholds and enable
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            for (int k = 0; k < 9; k++) w[k] = 8'($urandom);
            thr = 8'($urandom);
            en  = ($urandom % 5) != 0;
            if (i % 7 == 0) thr = 8'($urandom % 4);
            settle();
            check_all(en ? "random en" : "random R6 dis");
        end

        finish_run();
    end
endmodule